// File: doc/BRIEF.md
# Multiplexed-Bus Burst Write Slave

This block is a synchronous slave on a host bus that shares one set of wires for address and data. The host first places a start address on the bus and pulses an address-latch input while chip select is low. It then gives a one-cycle low strobe to open a write burst. After that it presents one 16-bit word per cycle. Each accepted word goes out on an internal memory write port, and the write address advances by one after each word.

The slave drives an active-low data-ready flag one cycle before it takes the first word. The burst has no fixed length: the host marks the final word with an active-low last-word flag. Raising chip select at any time during the burst abandons it. A downstream FIFO-full input holds off word capture. That input is reflected to the host on an active-low stop output. A word presented with word enables other than both-set is dropped, and a sticky error flag is raised. Only write bursts are handled. A strobe issued with the read/write select high starts nothing.

Top module: `burst_wr_slave`

## Requirements
- R1: While `cs_n` is low in idle, `addr_lat` high at a clock edge loads the start address from `bus_data[AW-1:0]`, and that address is the one used by the first write of the burst.
- R2: After an address load, a clock edge with `dstrb_n` low, `cs_n` low and `rd_wr_n` low starts the burst, and `rdy_n` is low from the next cycle.
- R3: If `cs_n` is high at any edge during the burst, the burst is abandoned: `rdy_n` is high and `mem_we` is low in the following cycle, and no further words are written until a new address load.
- R4: The first word is captured at the edge that ends the first cycle in which `rdy_n` is low. A capture at an edge gives `mem_we` high in the following cycle, with `mem_addr` and `mem_wdata` equal to that word's address and bus value.
- R5: Successive captured words go to consecutive addresses, each one higher than the previous.
- R6: The word captured at an edge where `last_n` is low is the final word. `rdy_n` is high in the following cycle, and later bus words are not written.
- R7: During a burst, `word_en` other than 2'b11 at an edge writes nothing and does not advance the address, and `err` is high from the next cycle on. `err` is cleared by the next address load.
- R8: `stop_n` is low in the cycle after any edge where `fifo_full` is high, and high otherwise. No word is captured at an edge where `fifo_full` is high, and the held word is taken once it drops.
- R9: After reset, `rdy_n` and `stop_n` are high and `mem_we` and `err` are low.
- R10: A strobe with `rd_wr_n` high starts no burst: `rdy_n` stays high and nothing is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| addr_lat | input | 1 | Address-latch pulse, active high |
| dstrb_n | input | 1 | Burst start strobe, active low |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| last_n | input | 1 | Low marks the final word |
| word_en | input | 2 | Byte-lane enables, 2'b11 required |
| bus_data | input | DW | Shared address/data bus |
| fifo_full | input | 1 | Downstream FIFO full |
| rdy_n | output | 1 | Data ready, active low |
| stop_n | output | 1 | Stop request, active low |
| err | output | 1 | Sticky word-enable error |
| mem_we | output | 1 | Memory write valid, one cycle per word |
| mem_addr | output | AW | Memory write address |
| mem_wdata | output | DW | Memory write data |

## Verification
A controller stuck in the wrong state shows up within one cycle. `rdy_n` fails to fall after the strobe, or it stays low after the last word or after an abandon. A write pulse may also appear when none should. An address counter that is loaded or advanced wrongly shows up on the first `mem_addr` that follows. That includes an advance on a dropped word, which shows as a skipped address in the next write. Stall and error handling are seen through `stop_n`, `err` and a missing or late `mem_we` one cycle after the edge concerned.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_XFER  = 2'd2,
    ST_DONE  = 2'd3
  } bst_e;

  localparam logic [1:0] FULL_WORD_EN = 2'b11;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       addr_lat,
  input  logic       dstrb_n,
  input  logic       rd_wr_n,
  input  logic       last_n,
  input  logic [1:0] word_en,
  input  logic       fifo_full,
  output logic       load,
  output logic       cap,
  output logic       rdy_n,
  output logic       stop_n,
  output logic       err
);
  bst_e state;
  logic in_xfer;
  logic en_ok;

  assign in_xfer = (state == ST_XFER) && !cs_n;
  assign en_ok   = (word_en == FULL_WORD_EN);
  assign load    = (state == ST_IDLE) && !cs_n && addr_lat;
  assign cap     = in_xfer && en_ok && !fifo_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      rdy_n  <= 1'b1;
      stop_n <= 1'b1;
      err    <= 1'b0;
    end else begin
      stop_n <= !fifo_full;
      case (state)
        ST_IDLE: begin
          if (load) begin
            state <= ST_ARMED;
            err   <= 1'b0;
          end
        end
        ST_ARMED: begin
          if (cs_n) begin
            state <= ST_IDLE;
          end else if (!dstrb_n && !rd_wr_n) begin
            state <= ST_XFER;
            rdy_n <= 1'b0;
          end
        end
        ST_XFER: begin
          if (cs_n) begin
            state <= ST_IDLE;
            rdy_n <= 1'b1;
          end else begin
            if (!en_ok) err <= 1'b1;
            if (cap && !last_n) begin
              state <= ST_DONE;
              rdy_n <= 1'b1;
            end
          end
        end
        default: begin
          if (cs_n) state <= ST_IDLE;
        end
      endcase
    end
  end

  AST_IDLE_RDY_HIGH: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE || state == ST_DONE) |-> rdy_n); // R6
  AST_CS_ABANDON: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> rdy_n); // R3
  AST_NO_CAP_FULL: assert property (@(posedge clk) disable iff (rst)
    fifo_full |=> !stop_n); // R8
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] ONE = AW'(1);

  always_ff @(posedge clk) begin
    if (rst)       addr <= '0;
    else if (load) addr <= load_val;
    else if (inc)  addr <= addr + ONE;
  end

  AST_HOLD_NO_INC: assert property (@(posedge clk) disable iff (rst)
    (!load && !inc) |=> $stable(addr)); // R7
endmodule

// File: rtl/burst_wr_port.sv
module burst_wr_port #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap,
  input  logic [AW-1:0] cap_addr,
  input  logic [DW-1:0] cap_data,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we <= 1'b0;
    end else begin
      mem_we <= cap;
    end
  end

  always_ff @(posedge clk) begin
    if (cap) begin
      mem_addr  <= cap_addr;
      mem_wdata <= cap_data;
    end
  end
endmodule

// File: rtl/burst_wr_slave.sv
module burst_wr_slave #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          addr_lat,
  input  logic          dstrb_n,
  input  logic          rd_wr_n,
  input  logic          last_n,
  input  logic [1:0]    word_en,
  input  logic [DW-1:0] bus_data,
  input  logic          fifo_full,
  output logic          rdy_n,
  output logic          stop_n,
  output logic          err,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);
  logic          load;
  logic          cap;
  logic [AW-1:0] cur_addr;

  burst_ctrl u_ctrl (
    .clk(clk), .rst(rst), .cs_n(cs_n), .addr_lat(addr_lat),
    .dstrb_n(dstrb_n), .rd_wr_n(rd_wr_n), .last_n(last_n),
    .word_en(word_en), .fifo_full(fifo_full),
    .load(load), .cap(cap), .rdy_n(rdy_n), .stop_n(stop_n), .err(err)
  );

  burst_addr_gen #(.AW(AW)) u_addr (
    .clk(clk), .rst(rst), .load(load), .load_val(bus_data[AW-1:0]),
    .inc(cap), .addr(cur_addr)
  );

  burst_wr_port #(.AW(AW), .DW(DW)) u_port (
    .clk(clk), .rst(rst), .cap(cap), .cap_addr(cur_addr),
    .cap_data(bus_data), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata)
  );

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + AW'(1))); // R5
  AST_WE_FULL_EN: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ($past(word_en) == 2'b11)); // R7
  AST_WE_NOT_FULL: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !$past(fifo_full)); // R8
  AST_WE_WHILE_RDY: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !$past(rdy_n)); // R4
endmodule

// File: tb/burst_wr_slave_bench.sv
`timescale 1ns/1ps
module burst_wr_slave_bench;
  localparam int AW = 12;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          cs_n, addr_lat, dstrb_n, rd_wr_n, last_n, fifo_full;
  logic [1:0]    word_en;
  logic [DW-1:0] bus_data;
  logic          rdy_n, stop_n, err, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  burst_wr_slave #(.AW(AW), .DW(DW)) u_burst_wr_slave (
    .clk(clk), .rst(rst), .cs_n(cs_n), .addr_lat(addr_lat),
    .dstrb_n(dstrb_n), .rd_wr_n(rd_wr_n), .last_n(last_n),
    .word_en(word_en), .bus_data(bus_data), .fifo_full(fifo_full),
    .rdy_n(rdy_n), .stop_n(stop_n), .err(err), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle_bus();
    cs_n = 1'b1; addr_lat = 1'b0; dstrb_n = 1'b1; rd_wr_n = 1'b0;
    last_n = 1'b1; word_en = 2'b11; fifo_full = 1'b0; bus_data = '0;
  endtask

  // Ends at a negedge with the burst running; rdy_n should be low here.
  task automatic start_burst(input logic [AW-1:0] a);
    @(negedge clk); cs_n = 1'b0; addr_lat = 1'b1; bus_data = DW'(a);
    @(negedge clk); addr_lat = 1'b0; dstrb_n = 1'b0; bus_data = 16'hDEAD;
    @(negedge clk); dstrb_n = 1'b1;
  endtask

  task automatic finish_burst();
    cs_n = 1'b1; last_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    idle_bus(); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 rdy_n", rdy_n, 1); chk("R9 stop_n", stop_n, 1);
    chk("R9 mem_we", mem_we, 0); chk("R9 err", err, 0);
  endtask

  task automatic t_basic();
    start_burst(12'h010);
    chk("R2 rdy_n low", rdy_n, 0); chk("R2 no write yet", mem_we, 0);
    bus_data = 16'hA000;
    @(negedge clk);
    chk("R4 we", mem_we, 1); chk("R1 addr", mem_addr, 12'h010); chk("R4 data", mem_wdata, 16'hA000);
    bus_data = 16'hA001;
    @(negedge clk);
    chk("R5 addr", mem_addr, 12'h011); chk("R5 data", mem_wdata, 16'hA001);
    bus_data = 16'hA002; last_n = 1'b0;
    @(negedge clk);
    chk("R5 addr3", mem_addr, 12'h012); chk("R6 we last", mem_we, 1); chk("R6 rdy_n", rdy_n, 1);
    bus_data = 16'hA003; last_n = 1'b1;
    @(negedge clk);
    chk("R6 after last", mem_we, 0);
    finish_burst();
  endtask

  task automatic t_abort();
    start_burst(12'h020);
    bus_data = 16'hB000;
    @(negedge clk);
    chk("R4 abort first", mem_we, 1);
    cs_n = 1'b1; bus_data = 16'hB001;
    @(negedge clk);
    chk("R3 we", mem_we, 0); chk("R3 rdy_n", rdy_n, 1);
    cs_n = 1'b0; bus_data = 16'hB002;
    @(negedge clk);
    chk("R3 stays idle", mem_we, 0); chk("R3 rdy_n idle", rdy_n, 1);
    finish_burst();
  endtask

  task automatic t_bad_en();
    start_burst(12'h030);
    word_en = 2'b01; bus_data = 16'hC0FF;
    @(negedge clk);
    chk("R7 no write", mem_we, 0); chk("R7 err", err, 1);
    word_en = 2'b11; bus_data = 16'hC000; last_n = 1'b0;
    @(negedge clk);
    chk("R7 we", mem_we, 1); chk("R7 addr held", mem_addr, 12'h030);
    chk("R7 data", mem_wdata, 16'hC000);
    finish_burst();
    chk("R7 err sticky", err, 1);
    start_burst(12'h040);
    chk("R7 err cleared", err, 0);
    fifo_full = 1'b1; bus_data = 16'hD000;
    @(negedge clk);
    chk("R8 stop_n", stop_n, 0); chk("R8 held", mem_we, 0);
    fifo_full = 1'b0; last_n = 1'b0;
    @(negedge clk);
    chk("R8 stop_n back", stop_n, 1); chk("R8 we", mem_we, 1);
    chk("R8 addr", mem_addr, 12'h040); chk("R8 data", mem_wdata, 16'hD000);
    finish_burst();
  endtask

  task automatic t_read();
    @(negedge clk); cs_n = 1'b0; addr_lat = 1'b1; bus_data = 16'h0050;
    @(negedge clk); addr_lat = 1'b0; dstrb_n = 1'b0; rd_wr_n = 1'b1;
    @(negedge clk); dstrb_n = 1'b1; rd_wr_n = 1'b0; bus_data = 16'hE000;
    chk("R10 rdy_n", rdy_n, 1);
    @(negedge clk);
    chk("R10 no write", mem_we, 0);
    finish_burst();
  endtask

  initial begin
    t_reset();
    t_basic();
    t_abort();
    t_bad_en();
    t_read();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule